// File: doc/BRIEF.md
# Serial Field Memory Write Port

This block is the write half of a serial-access field memory. Twelve-bit words arrive on a single write clock and are placed at consecutive addresses of a parameterised single-port RAM. A pointer-clear input sampled on the clock edge restarts the address sequence at zero. Two qualifiers shape each cycle. An advance enable moves the pointer and takes in a word. A separate store enable lets the pointer keep moving but keeps the word out of the array. The store enable allows selected regions of a stored field to be overwritten while the rest stays intact, for example an inset picture.

Each accepted word waits in a one-entry staging register. It reaches the RAM port when the next word is accepted, or when the next pointer clear flushes it. The word captured on an active edge is the one that was on the data input one edge earlier. A downstream unit can therefore sample an upstream unit's output directly. Two sticky-style flags report protocol misuse: a clear repeated too soon, and a pass that ended with too few accepted words.

Top module: `fm_wr_port`

## Requirements
- R1: On a rising edge where `wr_clr_i` is high, `wr_ptr_o` becomes 0 after that edge. `wr_en_i` and `store_en_i` are ignored on that edge: no word is taken in.
- R2: On a rising edge with `wr_clr_i` low and `wr_en_i` high, a word is accepted and `wr_ptr_o` increments by one. With `wr_en_i` low, nothing is accepted and `wr_ptr_o` holds.
- R3: A word accepted while `store_en_i` is low is never written: its commit cycle shows `ram_we_o` low. The pointer still advances as in R2.
- R4: The pointer wraps from DEPTH-1 to 0 on the next accepted word.
- R5: The data stored for a word accepted at edge k is the value of `din_i` sampled at edge k-1. Its address is the `wr_ptr_o` value before edge k.
- R6: An accepted word is held back until the next accepted word or the next clear edge. In the cycle after that edge, `ram_we_o`, `ram_addr_o` and `ram_data_o` present it together for exactly one cycle. A clear leaves nothing held.
- R7: If `wr_clr_i` is sampled high when fewer than 2 edges with it low have passed since the previous clear, `gap_err_o` goes high after that edge and stays high until `rst`.
- R8: At each clear except the first after `rst`, `short_pass_o` is set to 1 if fewer than 80 words were accepted since the previous clear, and to 0 otherwise. It holds its value between clears.
- R9: While `rst` is high, after the edge `wr_ptr_o`, `ram_we_o`, `gap_err_o` and `short_pass_o` are 0 and no word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_clr_i | input | 1 | Pointer clear, sampled on the rising edge |
| wr_en_i | input | 1 | Advance enable: accept word and move pointer |
| store_en_i | input | 1 | Store enable: low keeps the word out of the array |
| din_i | input | 12 | Input word |
| wr_ptr_o | output | $clog2(DEPTH) | Current write pointer |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | $clog2(DEPTH) | RAM write address |
| ram_data_o | output | 12 | RAM write data |
| gap_err_o | output | 1 | Clear repeated too soon (sticky) |
| short_pass_o | output | 1 | Last closed pass had fewer than 80 words |

## Verification
Corruption of the pointer shows on `wr_ptr_o` one cycle after the faulty edge. It then shows again on `ram_addr_o` when that word is committed, which happens at the next accepted word or clear. A staging entry that is lost or duplicated appears as a missing strobe, or as a strobe carrying the wrong address or data, in the cycle after the following accept or clear. A lost mask bit shows there as a strobe that should have been low. Errors in the pass counter or the gap counter stay hidden until the next clear, which is the first point where either flag can change.

// File: rtl/fm_wr_pkg.sv
package fm_wr_pkg;
  localparam int unsigned WORD_W = 12;

  typedef struct packed {
    logic              store;
    logic [WORD_W-1:0] data;
  } stage_word_t;
endpackage

// File: rtl/fm_wr_ptr.sv
module fm_wr_ptr #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [AW-1:0] ptr_nxt;

  generate
    if (POW2) begin : g_natural_wrap
      always_comb ptr_nxt = ptr + AW'(1);
    end else begin : g_compare_wrap
      always_comb ptr_nxt = (ptr == AW'(DEPTH-1)) ? '0 : ptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (adv)   ptr <= ptr_nxt;
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(ptr));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && adv && ptr == AW'(DEPTH-1)) |=> (ptr == '0));
endmodule

// File: rtl/fm_wr_stage.sv
module fm_wr_stage
  import fm_wr_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [AW-1:0]     push_addr,
  input  stage_word_t       push_word,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [WORD_W-1:0] ram_data
);
  logic          held_v;
  logic [AW-1:0] held_addr;
  stage_word_t   held_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v    <= 1'b0;
      held_addr <= '0;
      held_word <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_data  <= '0;
    end else begin
      ram_we <= 1'b0;
      if ((clr || push) && held_v) begin
        ram_we   <= held_word.store;
        ram_addr <= held_addr;
        ram_data <= held_word.data;
      end
      if (clr) begin
        held_v <= 1'b0;
      end else if (push) begin
        held_v    <= 1'b1;
        held_addr <= push_addr;
        held_word <= push_word;
      end
    end
  end

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !held_v);

  // R6
  commit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(clr || push));

  // R6
  push_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> held_v);
endmodule

// File: rtl/fm_wr_mon.sv
module fm_wr_mon #(
  parameter int unsigned MIN_PASS = 80,
  parameter int unsigned MIN_GAP  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic gap_err,
  output logic short_pass
);
  localparam int unsigned CW = $clog2(MIN_PASS + 1);
  localparam int unsigned GW = $clog2(MIN_GAP + 1);

  logic          seen;
  logic [CW-1:0] act_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen       <= 1'b0;
      act_cnt    <= '0;
      gap_cnt    <= '0;
      gap_err    <= 1'b0;
      short_pass <= 1'b0;
    end else if (clr) begin
      if (seen && gap_cnt < GW'(MIN_GAP)) gap_err <= 1'b1;
      if (seen) short_pass <= (act_cnt < CW'(MIN_PASS));
      seen    <= 1'b1;
      act_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      if (gap_cnt < GW'(MIN_GAP)) gap_cnt <= gap_cnt + GW'(1);
      if (adv && act_cnt < CW'(MIN_PASS)) act_cnt <= act_cnt + CW'(1);
    end
  end

  // R7
  gap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    gap_err |=> gap_err);

  // R8
  short_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> $stable(short_pass));
endmodule

// File: rtl/fm_wr_port.sv
module fm_wr_port
  import fm_wr_pkg::*;
#(
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned MIN_PASS = 80,
  parameter int unsigned MIN_GAP  = 2,
  parameter int unsigned AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_clr_i,
  input  logic              wr_en_i,
  input  logic              store_en_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [WORD_W-1:0] ram_data_o,
  output logic              gap_err_o,
  output logic              short_pass_o
);
  logic [WORD_W-1:0] din_q;
  logic              adv;
  stage_word_t       push_word;

  // one-edge lag on the data path for direct chaining
  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= din_i;
  end

  always_comb begin
    adv             = wr_en_i && !wr_clr_i;
    push_word.store = store_en_i;
    push_word.data  = din_q;
  end

  fm_wr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk (clk),
    .rst (rst),
    .clr (wr_clr_i),
    .adv (adv),
    .ptr (wr_ptr_o)
  );

  fm_wr_stage #(.AW(AW)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .clr       (wr_clr_i),
    .push      (adv),
    .push_addr (wr_ptr_o),
    .push_word (push_word),
    .ram_we    (ram_we_o),
    .ram_addr  (ram_addr_o),
    .ram_data  (ram_data_o)
  );

  fm_wr_mon #(.MIN_PASS(MIN_PASS), .MIN_GAP(MIN_GAP)) u_mon (
    .clk        (clk),
    .rst        (rst),
    .clr        (wr_clr_i),
    .adv        (adv),
    .gap_err    (gap_err_o),
    .short_pass (short_pass_o)
  );

  // R9
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (wr_ptr_o == '0 && !ram_we_o && !gap_err_o && !short_pass_o));
endmodule

// File: tb/fm_wr_port_bench.sv
module fm_wr_port_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_clr_i = 1'b0, wr_en_i = 1'b0, store_en_i = 1'b0;
  logic [11:0]   din_i = '0;
  logic [AW-1:0] wr_ptr_o, ram_addr_o;
  logic [11:0]   ram_data_o;
  logic          ram_we_o, gap_err_o, short_pass_o;

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  int m_ptr = 0, m_we = 0, m_addr = 0, m_data = 0, m_err = 0, m_short = 0;
  int m_prev = 0, m_seen = 0, m_act = 0, m_gap = 0, m_masked = 0;
  int qa[$], qd[$], qs[$];
  string ptr_tag = "R9";

  always #(CLK_P/2) clk = ~clk;

  fm_wr_port #(.DEPTH(DEPTH)) u_fm_wr_port (
    .clk(clk), .rst(rst), .wr_clr_i(wr_clr_i), .wr_en_i(wr_en_i),
    .store_en_i(store_en_i), .din_i(din_i), .wr_ptr_o(wr_ptr_o),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_data_o(ram_data_o),
    .gap_err_o(gap_err_o), .short_pass_o(short_pass_o)
  );

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_ptr = 0; m_we = 0; m_err = 0; m_short = 0; m_prev = 0;
      m_seen = 0; m_act = 0; m_gap = 0; m_masked = 0;
      qa.delete(); qd.delete(); qs.delete();
      ptr_tag = "R9";
    end else begin
      m_we = 0; m_masked = 0;
      if (wr_clr_i) begin
        if (qa.size() > 0) begin
          m_we = qs[0]; m_addr = qa[0]; m_data = qd[0]; m_masked = !qs[0];
          qa.delete(); qd.delete(); qs.delete();
        end
        if (m_seen && m_gap < 2) m_err = 1;
        if (m_seen) m_short = (m_act < 80);
        m_seen = 1; m_act = 0; m_gap = 0; m_ptr = 0;
        ptr_tag = "R1";
      end else begin
        if (m_gap < 2) m_gap++;
        ptr_tag = "R2";
        if (wr_en_i) begin
          if (qa.size() > 0) begin
            m_we = qs[0]; m_addr = qa[0]; m_data = qd[0]; m_masked = !qs[0];
            void'(qa.pop_front()); void'(qd.pop_front()); void'(qs.pop_front());
          end
          qa.push_back(m_ptr); qd.push_back(m_prev); qs.push_back(int'(store_en_i));
          if (m_ptr == DEPTH-1) ptr_tag = "R4";
          m_ptr = (m_ptr + 1) % DEPTH;
          if (m_act < 80) m_act++;
        end
      end
      m_prev = int'(din_i);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #(CLK_P/4);
    cmp(ptr_tag, int'(wr_ptr_o), m_ptr);
    cmp(m_masked ? "R3" : "R6", int'(ram_we_o), m_we);
    if (m_we != 0) begin
      cmp("R5", int'(ram_data_o), m_data);
      cmp("R6", int'(ram_addr_o), m_addr);
    end
    cmp("R7", int'(gap_err_o), m_err);
    cmp("R8", int'(short_pass_o), m_short);
  endtask

  task automatic drive(logic c, logic w, logic s, logic [11:0] d);
    wr_clr_i = c; wr_en_i = w; store_en_i = s; din_i = d;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL R9 watchdog: actual %0d cycles expected under 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P/4);
    // R9 reset state
    repeat (3) tick();
    cmp("R9", int'(ram_we_o) + int'(gap_err_o) + int'(short_pass_o) + int'(wr_ptr_o), 0);
    rst = 1'b0;
    repeat (3) drive(0, 0, 1, 12'h0);
    drive(1, 0, 0, 12'h0);                      // first clear: no flags
    repeat (2) drive(0, 0, 1, 12'h0);
    // pass A: long, with advance gaps and masked words (R2, R3, R5)
    for (int i = 0; i < 120; i++)
      drive(0, (i % 9) != 4, (i % 7) != 3, 12'((i * 37 + 5) & 12'hFFF));
    drive(0, 0, 1, 12'h0);
    drive(1, 0, 1, 12'h0);                      // flush, long pass
    cmp("R8", int'(short_pass_o), 0);
    cmp("R1", int'(wr_ptr_o), 0);
    repeat (2) drive(0, 0, 1, 12'h0);
    // pass B: short (R8)
    for (int i = 0; i < 10; i++) drive(0, 1, 1, 12'(12'hA00 + i));
    drive(1, 1, 1, 12'h5A5);                    // clear wins over advance (R1)
    cmp("R8", int'(short_pass_o), 1);
    cmp("R1", int'(wr_ptr_o), 0);
    // clear too soon (R7)
    drive(0, 1, 0, 12'h111);
    drive(1, 0, 0, 12'h0);
    cmp("R7", int'(gap_err_o), 1);
    repeat (3) drive(0, 0, 0, 12'h0);
    cmp("R7", int'(gap_err_o), 1);
    // reset clears flags (R9)
    rst = 1'b1;
    tick();
    cmp("R9", int'(gap_err_o), 0);
    rst = 1'b0;
    drive(1, 0, 0, 12'h0);
    repeat (2) drive(0, 0, 0, 12'h0);
    // wrap pass (R4)
    for (int i = 0; i < DEPTH; i++) drive(0, 1, (i % 5) != 0, 12'(i ^ 12'h3C3));
    cmp("R4", int'(wr_ptr_o), 0);
    for (int i = 0; i < 6; i++) drive(0, 1, 1, 12'(12'hF00 + i));
    drive(1, 1, 0, 12'h0);
    cmp("R8", int'(short_pass_o), 0);
    repeat (3) drive(0, 0, 0, 12'h0);
    cmp("R6", int'(ram_we_o), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule